// File: doc/BRIEF.md
# Serial DAC Word Transmitter

This block accepts signed 20-bit samples from a parallel producer over a valid/ready handshake. It turns each sample into a serial frame for an external audio DAC. It drives a bit clock, a serial data line and an active-low latch strobe. The bit clock is made from the system clock by a programmable divider with an even duty cycle. Each frame lasts 24 bit clocks. The first 4 bits are zero padding and the last 20 bits carry the sample in two's complement, most significant bit first. The receiver keeps only the last 20 bits it shifted in before the strobe falls.

Both the data line and the strobe change only where the bit clock falls, so they are steady at the receiver's rising-edge sample point. The strobe falls at the falling edge that ends the least significant bit. It stays low for two bit clocks and is then high for the rest of the frame. When the producer has no sample ready at a frame boundary, one of two things happens:
- With the stop option off, the previous sample is sent again.
- With the stop option on, the bit clock is parked low and the strobe stays low until the next word has started.

Top module: `sdac_tx`

## Requirements
- R1: Between two falling strobe edges there are exactly 24 rising bit-clock edges. The last 20 bits sampled on those edges equal the accepted 20-bit sample, MSB first.
- R2: The first 4 bits of every frame are 0.
- R3: The serial data and the strobe change only when the bit clock falls. They hold steady while the bit clock is high.
- R4: The strobe falls at the bit-clock falling edge that ends the last bit of a frame. At least one rising bit-clock edge comes before it while the strobe is high.
- R5: After the strobe falls, it stays low for exactly 2 rising bit-clock edges of the next word before it rises.
- R6: With `stop_en` = 1 and no valid sample at a frame boundary, the bit clock stays at 0 and the strobe stays at 0 until a sample is accepted.
- R7: With `stop_en` = 0 and no valid sample at a frame boundary, the previously held sample is sent again. After reset the held sample is 0.
- R8: `s_ready` is high at a frame boundary and while parked. A transfer happens when `s_valid` and `s_ready` are both high. While running, `s_ready` is high for one system clock per frame.
- R9: The bit clock's high and low phases each last max(`half_div`,1) system clocks while running. The value 0 acts as 1.
- R10: After reset the block is parked: `bclk_o`=0, `le_n_o`=1, `sdata_o`=0 and `s_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| half_div | input | 8 | Bit-clock half period in system clocks (0 treated as 1) |
| stop_en | input | 1 | Park the bit clock when no sample is available |
| s_valid | input | 1 | Sample valid |
| s_ready | output | 1 | Sample accepted this cycle when valid |
| s_data | input | 20 | Signed sample, two's complement |
| bclk_o | output | 1 | Serial bit clock |
| sdata_o | output | 1 | Serial data, MSB first |
| le_n_o | output | 1 | Active-low latch strobe |

## Verification
A wrong slot counter shows up at the next strobe fall. The DAC-side model then sees a count other than 24 rising edges, non-zero padding, or a shifted word. A fault in the strobe or handshake state shows up within one frame:
- a low phase that does not last two bit clocks;
- a ready pulse that lasts longer than one cycle;
- a bit clock that keeps running while parked.

A divider fault breaks the high-phase width at the very next bit-clock fall.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
    parameter int SAMPLE_W    = 20;
    parameter int FRAME_LEN   = 24;
    parameter int DIV_W       = 8;
    parameter int LE_LOW_BITS = 2;

    localparam int PAD_BITS = FRAME_LEN - SAMPLE_W;
    localparam int SLOT_W   = $clog2(FRAME_LEN);

    typedef logic [SAMPLE_W-1:0] sample_t;
    typedef logic [SLOT_W-1:0]   slot_t;

    typedef enum logic {ST_IDLE, ST_RUN} tx_st_e;

    typedef struct packed {
        tx_st_e st;
        slot_t  slot;
        logic   sd;
        logic   le_n;
    } tx_state_t;

    // Bit carried by a given slot: zero padding first, then sample MSB first.
    function automatic logic frame_bit(sample_t w, slot_t s);
        if (int'(s) < PAD_BITS) return 1'b0;
        return w[FRAME_LEN - 1 - int'(s)];
    endfunction
endpackage

// File: rtl/sdac_bclk_div.sv
module sdac_bclk_div
    import sdac_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             bclk,
    output logic             fall_evt
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] half_eff;
    logic             hit;

    assign half_eff = (half_div == '0) ? DIV_W'(1) : half_div;
    assign hit      = (cnt >= half_eff - DIV_W'(1));
    assign fall_evt = run && hit && bclk;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt  <= '0;
            bclk <= 1'b0;
        end else if (hit) begin
            cnt  <= '0;
            bclk <= ~bclk;
        end else begin
            cnt  <= cnt + DIV_W'(1);
        end
    end
endmodule

// File: rtl/sdac_framer.sv
module sdac_framer
    import sdac_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    stop_en,
    input  logic    s_valid,
    output logic    s_ready,
    input  sample_t s_data,
    input  logic    bclk,
    input  logic    fall_evt,
    output logic    run,
    output logic    sdata,
    output logic    le_n
);
    localparam slot_t LAST_SLOT = slot_t'(FRAME_LEN - 1);
    localparam slot_t LE_UP     = slot_t'(LE_LOW_BITS);

    tx_state_t r, nxt;
    sample_t   held, held_nxt, word;
    logic      frame_end, take, go;
    slot_t     slot_inc;

    assign run       = (r.st == ST_RUN);
    assign frame_end = run && fall_evt && (r.slot == LAST_SLOT);
    assign s_ready   = (r.st == ST_IDLE) || frame_end;
    assign take      = s_ready && s_valid;
    assign go        = s_ready && (s_valid || !stop_en);
    assign word      = take ? s_data : held;
    assign slot_inc  = r.slot + slot_t'(1);
    assign sdata     = r.sd;
    assign le_n      = r.le_n;

    always_comb begin
        nxt      = r;
        held_nxt = take ? s_data : held;
        if (go) begin
            nxt.st   = ST_RUN;
            nxt.slot = '0;
            nxt.sd   = frame_bit(word, '0);
            if (frame_end) nxt.le_n = 1'b0;
        end else if (frame_end) begin
            nxt.st   = ST_IDLE;
            nxt.slot = '0;
            nxt.sd   = 1'b0;
            nxt.le_n = 1'b0;
        end else if (run && fall_evt) begin
            nxt.slot = slot_inc;
            nxt.sd   = frame_bit(held, slot_inc);
            if (slot_inc == LE_UP) nxt.le_n = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r    <= '{st: ST_IDLE, slot: '0, sd: 1'b0, le_n: 1'b1};
            held <= '0;
        end else begin
            r    <= nxt;
            held <= held_nxt;
        end
    end

    AST_STABLE_WHILE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (bclk && $past(bclk)) |-> ($stable(r.sd) && $stable(r.le_n))); // R3

    AST_LE_FALLS_WITH_BCLK: assert property (@(posedge clk) disable iff (rst)
        $fell(r.le_n) |-> (!bclk && $past(bclk))); // R4

    AST_READY_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (s_ready && (s_valid || !stop_en)) |=> !s_ready); // R8

    AST_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (run && (int'(r.slot) < PAD_BITS)) |-> !r.sd); // R2
endmodule

// File: rtl/sdac_tx.sv
module sdac_tx
    import sdac_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [DIV_W-1:0]    half_div,
    input  logic                stop_en,
    input  logic                s_valid,
    output logic                s_ready,
    input  logic [SAMPLE_W-1:0] s_data,
    output logic                bclk_o,
    output logic                sdata_o,
    output logic                le_n_o
);
    logic run, fall_evt, bclk;

    sdac_bclk_div u_div (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .half_div (half_div),
        .bclk     (bclk),
        .fall_evt (fall_evt)
    );

    sdac_framer u_framer (
        .clk      (clk),
        .rst      (rst),
        .stop_en  (stop_en),
        .s_valid  (s_valid),
        .s_ready  (s_ready),
        .s_data   (s_data),
        .bclk     (bclk),
        .fall_evt (fall_evt),
        .run      (run),
        .sdata    (sdata_o),
        .le_n     (le_n_o)
    );

    assign bclk_o = bclk;
endmodule

// File: tb/sdac_tx_bench.sv
module sdac_tx_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  half_div;
    logic        stop_en;
    logic        s_valid;
    logic        s_ready;
    logic [19:0] s_data;
    logic        bclk_o, sdata_o, le_n_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [19:0] exp_q[$];
    logic [19:0] last_word = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdac_tx u_sdac_tx (
        .clk(clk), .rst(rst), .half_div(half_div), .stop_en(stop_en),
        .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
        .bclk_o(bclk_o), .sdata_o(sdata_o), .le_n_o(le_n_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver: offers one sample and records it as expected once taken.
    task automatic send(input logic [19:0] d);
        s_data  = d;
        s_valid = 1'b1;
        forever begin
            @(negedge clk);
            if (s_ready) break;
        end
        exp_q.push_back(d);
        @(posedge clk); #1;
        s_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(posedge clk);
        repeat (10) @(posedge clk);
        #1;
    endtask

    // Monitor: DAC-side model and scoreboard.
    logic        prev_bclk = 0, prev_le = 1, prev_take = 0;
    logic [23:0] shreg = '0;
    int rise_cnt = 0, hi_rises = 0, lo_rises = 0, hi_len = 0;
    bit mon_on = 0;

    always @(negedge clk) begin
        if (mon_on) begin
            int h_exp;
            h_exp = (half_div == 0) ? 1 : int'(half_div);
            // R8: ready drops after a running transfer
            if (prev_take) check(!s_ready, "R8 ready one cycle", s_ready, 0);
            prev_take = s_ready && (s_valid || !stop_en);
            // R7: resend expectation at a boundary without a sample
            if (s_ready && s_valid) last_word = s_data;
            else if (s_ready && !stop_en) exp_q.push_back(last_word);

            if (bclk_o && !prev_bclk) begin
                shreg = {shreg[22:0], sdata_o};
                rise_cnt++;
                if (le_n_o) hi_rises++; else lo_rises++;
            end
            if (bclk_o) hi_len++;
            if (!bclk_o && prev_bclk) begin
                check(hi_len == h_exp, "R9 high phase width", hi_len, h_exp);
                hi_len = 0;
            end
            if (!le_n_o && prev_le) begin
                check(rise_cnt == 24, "R1 bits per frame", rise_cnt, 24);
                check(shreg[23:20] == 4'h0, "R2 padding zero", shreg[23:20], 0);
                check(hi_rises >= 1, "R4 strobe high before fall", hi_rises, 1);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R1 unexpected latch", shreg[19:0], 0);
                end else begin
                    logic [19:0] e;
                    e = exp_q.pop_front();
                    check(shreg[19:0] == e, "R1/R7 latched word", shreg[19:0], e);
                end
                rise_cnt = 0; hi_rises = 0; lo_rises = 0;
            end
            if (le_n_o && !prev_le)
                check(lo_rises == 2, "R5 strobe low width", lo_rises, 2);
        end
        prev_bclk = bclk_o;
        prev_le   = le_n_o;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1; half_div = 8'd2; stop_en = 1; s_valid = 0; s_data = '0;
        repeat (4) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        check(bclk_o == 0, "R10 reset bclk", bclk_o, 0);
        check(le_n_o == 1, "R10 reset strobe", le_n_o, 1);
        check(sdata_o == 0, "R10 reset data", sdata_o, 0);
        check(s_ready == 1, "R10 reset ready", s_ready, 1);
        mon_on = 1;
        begin
            bit moved = 0;
            repeat (40) begin @(negedge clk); if (bclk_o) moved = 1; end
            check(!moved, "R6 parked after reset", moved, 0);
        end
        @(posedge clk); #1;

        // R1/R2/R4/R5: back-to-back extremes and patterns
        send(20'h7FFFF); send(20'h80000); send(20'h00001);
        send(20'hFFFFF); send(20'h5A5A5);
        drain();

        // R6: stopped clock gap keeps bclk and strobe low
        begin
            bit bad = 0;
            repeat (100) begin @(negedge clk); if (bclk_o || le_n_o) bad = 1; end
            check(!bad, "R6 stopped gap", bad, 0);
        end
        @(posedge clk); #1;
        send(20'hA0F0F);
        drain();

        // R9: divider settings including zero
        half_div = 8'd1; send(20'h13579); send(20'h2468A); drain();
        half_div = 8'd3; send(20'h3C3C3); send(20'h00000); drain();
        half_div = 8'd0; send(20'hC0001); drain();

        // R7: resend previous sample when none is offered
        half_div = 8'd1;
        stop_en = 0;
        send(20'h12345);
        repeat (200) @(posedge clk);
        #1 stop_en = 1;
        drain();

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule